// File: doc/BRIEF.md
# Guarded Masked Control-Status Register

This block holds a 32-bit processor control and status word. Software changes it through a write operation made of a value word, a per-bit mask word and an optional guard bit. Only the bits selected by the mask change. A guarded write whose guard bit is low leaves the register as it was. Hardware reports floating-point events on the same word through a per-bit set vector. These events set sticky flags, and software clears a flag by writing it with its mask bit set.

When a software write and a hardware event land in the same cycle, the two are merged bit by bit. A bit that hardware sets takes the hardware value. Every other masked bit takes the software value. The block decodes three fields continuously: the rounding mode, the interrupt enable and the trap enables. It also gives the interrupt logic a copy of the exception flags and trap enables that lags the register by a fixed number of cycles.

Layout: exception flags at bits 6:0 (divide-by-zero 0, inexact 1, underflow 2, overflow 3, invalid 4, input flush 5, output flush 6), rounding mode at 8:7, interrupt enable at 10, trap enables at 22:16 (same order as the flags, offset 16), misaligned-store trap enable at 31. All other bits are undefined.

Top module: `csr_mask_arb`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the register, the decoded fields and the delayed interrupt view to 0.
- R2: An accepted software write loads (old & ~swMask) | (swValue & swMask). Bits whose mask bit is 0 keep their old value.
- R3: When guardEn is 1, a write is accepted only if guardBit is 1. With guardBit at 0 the register does not change.
- R4: When guardEn is 0, a write (swValid high) is accepted whatever guardBit holds.
- R5: An accepted write is visible on csrValue at the clock edge that samples it, so it can be read in the next cycle.
- R6: On a same-cycle collision, flag bits set by hwSet read 1. The other masked bits take swValue.
- R7: Flags set by hwSet (bits 6:0) stay 1 until a software write clears them with the matching mask bit set.
- R8: Undefined positions (all bits outside 6:0, 8:7, 10, 22:16 and 31) always read 0. Writes to them and hwSet bits outside 6:0 have no effect.
- R9: roundMode is bits 8:7 (0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf). intEnable is bit 10. trapEnable is {bit 31, bits 22:16}.
- R10: irqFlags and irqTrapEn show the flag field and the trap-enable field (packed as in R9) exactly 3 cycles after csrValue. They are unchanged at 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| swValid | input | 1 | Software write issued this cycle |
| guardEn | input | 1 | The write carries a guard |
| guardBit | input | 1 | Least significant bit of the guard operand |
| swValue | input | 32 | Value operand |
| swMask | input | 32 | Per-bit write mask |
| hwSet | input | 32 | Per-bit hardware event set vector |
| csrValue | output | 32 | Current register contents |
| roundMode | output | 2 | Rounding-mode field |
| intEnable | output | 1 | Interrupt enable |
| trapEnable | output | 8 | Trap enables {bit 31, bits 22:16} |
| irqFlags | output | 7 | Delayed exception flags |
| irqTrapEn | output | 8 | Delayed trap enables |

## Verification
A software write and a hardware flag event can fall in the same clock cycle. The bench provokes this by driving swValid with a mask that clears several flags and sets the interrupt enable, while hwSet raises one of those same flags. The result is correct only if that one flag reads 1 and the other cleared flags and the interrupt enable follow the software operand. A checker property judges every such cycle bit by bit against the previous state.

// File: rtl/csr_mask_pkg.sv
package csr_mask_pkg;

  localparam int CSR_W   = 32;
  localparam int FLAG_W  = 7;
  localparam int TRAP_W  = FLAG_W + 1;
  localparam int VIEW_W  = FLAG_W + TRAP_W;

  localparam int RM_LO     = 7;
  localparam int IEN_POS   = 10;
  localparam int TRAP_LO   = 16;
  localparam int MSTE_POS  = 31;

  localparam logic [CSR_W-1:0] FLAG_MASK = {{(CSR_W-FLAG_W){1'b0}}, {FLAG_W{1'b1}}};
  localparam logic [CSR_W-1:0] RM_MASK   = 32'h3 << RM_LO;
  localparam logic [CSR_W-1:0] IEN_MASK  = 32'h1 << IEN_POS;
  localparam logic [CSR_W-1:0] TRAP_MASK = (FLAG_MASK << TRAP_LO) | (32'h1 << MSTE_POS);
  localparam logic [CSR_W-1:0] DEF_MASK  = FLAG_MASK | RM_MASK | IEN_MASK | TRAP_MASK;

  typedef struct packed {
    logic swWrite;
    logic hwEvent;
  } csrStrobe_t;

  function automatic logic [TRAP_W-1:0] trapField(input logic [CSR_W-1:0] w);
    return {w[MSTE_POS], w[TRAP_LO +: FLAG_W]};
  endfunction

endpackage

// File: rtl/csr_mask_ctrl.sv
module csr_mask_ctrl
  import csr_mask_pkg::*;
(
  input  logic             swValid,
  input  logic             guardEn,
  input  logic             guardBit,
  input  logic [CSR_W-1:0] hwSet,
  output csrStrobe_t       strobe
);

  logic guardPass;

  always_comb begin
    guardPass      = !guardEn || guardBit;
    strobe.swWrite = swValid && guardPass;
    strobe.hwEvent = |(hwSet & FLAG_MASK);
  end

endmodule

// File: rtl/csr_mask_dp.sv
module csr_mask_dp
  import csr_mask_pkg::*;
#(
  parameter int IRQ_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  csrStrobe_t        strobe,
  input  logic [CSR_W-1:0]  swValue,
  input  logic [CSR_W-1:0]  swMask,
  input  logic [CSR_W-1:0]  hwSet,
  output logic [CSR_W-1:0]  csrValue,
  output logic [1:0]        roundMode,
  output logic              intEnable,
  output logic [TRAP_W-1:0] trapEnable,
  output logic [FLAG_W-1:0] irqFlags,
  output logic [TRAP_W-1:0] irqTrapEn
);

  logic [CSR_W-1:0] csrReg;
  logic [CSR_W-1:0] csrNext;
  logic [CSR_W-1:0] swMerged;
  logic [VIEW_W-1:0] viewNow;
  logic [VIEW_W-1:0] viewPipe [IRQ_DELAY];

  always_comb begin
    swMerged = strobe.swWrite ? ((csrReg & ~swMask) | (swValue & swMask)) : csrReg;
    csrNext  = swMerged;
    if (strobe.hwEvent) csrNext = csrNext | (hwSet & FLAG_MASK);
    csrNext  = csrNext & DEF_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) csrReg <= '0;
    else     csrReg <= csrNext;
  end

  assign viewNow = {trapField(csrReg), csrReg[FLAG_W-1:0]};

  generate
    for (genvar s = 0; s < IRQ_DELAY; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) viewPipe[s] <= '0;
        else if (s == 0) viewPipe[s] <= viewNow;
        else viewPipe[s] <= viewPipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign csrValue   = csrReg;
  assign roundMode  = csrReg[RM_LO +: 2];
  assign intEnable  = csrReg[IEN_POS];
  assign trapEnable = trapField(csrReg);
  assign irqFlags   = viewPipe[IRQ_DELAY-1][FLAG_W-1:0];
  assign irqTrapEn  = viewPipe[IRQ_DELAY-1][VIEW_W-1:FLAG_W];

endmodule

// File: rtl/csr_mask_arb.sv
module csr_mask_arb
  import csr_mask_pkg::*;
#(
  parameter int IRQ_DELAY = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        swValid,
  input  logic        guardEn,
  input  logic        guardBit,
  input  logic [31:0] swValue,
  input  logic [31:0] swMask,
  input  logic [31:0] hwSet,
  output logic [31:0] csrValue,
  output logic [1:0]  roundMode,
  output logic        intEnable,
  output logic [7:0]  trapEnable,
  output logic [6:0]  irqFlags,
  output logic [7:0]  irqTrapEn
);

  csrStrobe_t strobe;

  csr_mask_ctrl i_ctrl (
    .swValid  (swValid),
    .guardEn  (guardEn),
    .guardBit (guardBit),
    .hwSet    (hwSet),
    .strobe   (strobe)
  );

  csr_mask_dp #(.IRQ_DELAY(IRQ_DELAY)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .swValue    (swValue),
    .swMask     (swMask),
    .hwSet      (hwSet),
    .csrValue   (csrValue),
    .roundMode  (roundMode),
    .intEnable  (intEnable),
    .trapEnable (trapEnable),
    .irqFlags   (irqFlags),
    .irqTrapEn  (irqTrapEn)
  );

endmodule

// File: rtl/csr_mask_chk.sv
module csr_mask_chk
  import csr_mask_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        swValid,
  input logic        guardEn,
  input logic        guardBit,
  input logic [31:0] swMask,
  input logic [31:0] hwSet,
  input logic [31:0] csrValue,
  input logic [6:0]  irqFlags,
  input logic [7:0]  irqTrapEn
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (csrValue & ~DEF_MASK) == 32'h0); // R8

  AST_GUARD_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (swValid && guardEn && !guardBit && ((hwSet & FLAG_MASK) == 32'h0)) |=> $stable(csrValue)); // R3

  AST_HW_WINS: assert property (@(posedge clk) disable iff (rst)
    ((hwSet & FLAG_MASK) != 32'h0) |=>
      ((csrValue & $past(hwSet & FLAG_MASK)) == $past(hwSet & FLAG_MASK))); // R6

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
    (swValid && (!guardEn || guardBit)) |=>
      (((csrValue ^ $past(csrValue)) & ~$past(swMask) & ~$past(hwSet)) == 32'h0)); // R2

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3) |->
      ({irqTrapEn, irqFlags} == {$past(csrValue[31]), $past(csrValue[22:16]), $past(csrValue[6:0])} ) ||
      ({irqTrapEn, irqFlags} == {$past(csrValue[31], 3), $past(csrValue[22:16], 3), $past(csrValue[6:0], 3)})); // R10

endmodule

bind csr_mask_arb csr_mask_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .swValid   (swValid),
  .guardEn   (guardEn),
  .guardBit  (guardBit),
  .swMask    (swMask),
  .hwSet     (hwSet),
  .csrValue  (csrValue),
  .irqFlags  (irqFlags),
  .irqTrapEn (irqTrapEn)
);

// File: tb/test_csr_mask_arb.sv
module test_csr_mask_arb;

  logic        clk = 1'b0;
  logic        rst;
  logic        swValid, guardEn, guardBit;
  logic [31:0] swValue, swMask, hwSet;
  logic [31:0] csrValue;
  logic [1:0]  roundMode;
  logic        intEnable;
  logic [7:0]  trapEnable;
  logic [6:0]  irqFlags;
  logic [7:0]  irqTrapEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csr_mask_arb i_csr_mask_arb (
    .clk(clk), .rst(rst), .swValid(swValid), .guardEn(guardEn), .guardBit(guardBit),
    .swValue(swValue), .swMask(swMask), .hwSet(hwSet), .csrValue(csrValue),
    .roundMode(roundMode), .intEnable(intEnable), .trapEnable(trapEnable),
    .irqFlags(irqFlags), .irqTrapEn(irqTrapEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    swValid = 0; guardEn = 0; guardBit = 0; swValue = '0; swMask = '0; hwSet = '0;
  endtask

  // drive one cycle at a negedge, return at the next negedge with inputs idle
  task automatic op(input logic v, input logic ge, input logic gb,
                    input logic [31:0] val, input logic [31:0] msk, input logic [31:0] hw);
    swValid = v; guardEn = ge; guardBit = gb; swValue = val; swMask = msk; hwSet = hw;
    @(negedge clk);
    idle();
  endtask

  task automatic tReset();
    check("R1 csr", csrValue, 32'h0);
    check("R1 irqFlags", {25'h0, irqFlags}, 32'h0);
    check("R1 irqTrapEn", {24'h0, irqTrapEn}, 32'h0);
  endtask

  task automatic tMaskedWrite();
    op(1, 0, 0, 32'h100, 32'h180, 0);
    check("R5 csr after one cycle", csrValue, 32'h100);
    check("R9 roundMode toward +inf", {30'h0, roundMode}, 32'd2);
    op(1, 0, 0, 32'hFFFFFFFF, 32'h400, 0);
    check("R2 masked set keeps others", csrValue, 32'h500);
    check("R9 intEnable", {31'h0, intEnable}, 32'd1);
  endtask

  task automatic tGuard();
    op(1, 1, 0, 32'h0, 32'h400, 0);
    check("R3 guard low blocks", csrValue, 32'h500);
    op(1, 1, 1, 32'h0, 32'h400, 0);
    check("R3 guard high writes", csrValue, 32'h100);
  endtask

  task automatic tNoGuard();
    op(1, 0, 0, 32'h80110000, 32'hFFFF0000, 0);
    check("R4 unguarded write", csrValue, 32'h80110100);
    check("R9 trapEnable", {24'h0, trapEnable}, 32'h91);
  endtask

  task automatic tUndef();
    op(1, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    check("R8 undefined bits read 0", csrValue, 32'h807F05FF);
    op(1, 0, 0, 32'h0, 32'hFFFFFFFF, 0);
    op(0, 0, 0, 32'h0, 32'h0, 32'hFFFFFF80);
    check("R8 hwSet outside flags ignored", csrValue, 32'h0);
  endtask

  task automatic tSticky();
    op(0, 0, 0, 0, 0, 32'h5);
    check("R7 hw sets flags", csrValue, 32'h5);
    op(0, 0, 0, 0, 0, 0);
    check("R7 flags stay set", csrValue, 32'h5);
    op(1, 0, 0, 32'h0, 32'h1, 0);
    check("R7 masked clear", csrValue, 32'h4);
  endtask

  task automatic tCollision();
    op(1, 0, 0, 32'h400, 32'h407, 32'h2);
    check("R6 hw wins per bit", csrValue, 32'h402);
  endtask

  task automatic tDelay();
    repeat (4) @(negedge clk);
    check("R10 settled flags", {25'h0, irqFlags}, 32'h02);
    op(1, 0, 0, 32'h00100010, 32'h00100010, 0);
    check("R10 csr updated", csrValue, 32'h00100412);
    repeat (2) @(negedge clk);
    check("R10 flags unchanged at 2", {25'h0, irqFlags}, 32'h02);
    check("R10 traps unchanged at 2", {24'h0, irqTrapEn}, 32'h0);
    @(negedge clk);
    check("R10 flags at 3", {25'h0, irqFlags}, 32'h12);
    check("R10 traps at 3", {24'h0, irqTrapEn}, 32'h10);
  endtask

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tReset();
    tMaskedWrite();
    tGuard();
    tNoGuard();
    tUndef();
    tSticky();
    tCollision();
    tDelay();
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule